// File: doc/BRIEF.md
# Hashed direct-mapped decode cache

This block remembers instructions that have already been decoded, keyed by their fetch address, so a front end can skip decoding an address it has seen before. Every fetch address maps to exactly one slot. The slot index is not taken from the low address bits. It is a mix of a right-shifted and a left-shifted copy of the halfword address, which spreads nearby code and far-away call targets across the array. Each slot stores the complete fetch address as its tag and the decoded instruction word as its data. A tag of all ones marks a slot as empty.

A lookup is registered on the clock edge that accepts it. The result appears in the following cycle as a hit, with the stored word, or as a miss. After the decoder finishes an address, it writes the address and the decoded word through the fill port, together with a flag that says whether decoding succeeded. A flush input empties every slot in one cycle. The caller checks the address range before it looks anything up, so the all-ones address is never presented.

Top module: `dc_cache`

## Requirements
- R1: After reset, every slot is empty and `rsp_valid_o` is low. A lookup of any address that has not been filled returns `rsp_hit_o`=0.
- R2: `rsp_valid_o` is high in exactly the cycle after a cycle with `lkp_valid_i` high, and low otherwise.
- R3: With p = address >> 1, the slot index is ((p >> 5) XOR (p << 1)) mod ENTRIES. For example, addresses 0x0 and 0x1000 share the low halfword bits but map to different slots, so both can be resident at once.
- R4: A hit requires the stored tag to equal the lookup address in every bit. On a hit, `rsp_insn_o` is the stored word. On a miss, `rsp_hit_o`=0 and `rsp_insn_o`=0. For example, 0x201 misses after a fill of 0x200, even though both map to the same slot.
- R5: A fill writes a slot only when both `fill_valid_i` and `fill_ok_i` are high. A fill with `fill_ok_i`=0 leaves the cache unchanged.
- R6: A cycle with `flush_i` high sets every tag to all ones, so that every later lookup misses until new fills arrive.
- R7: When `flush_i` and a valid fill are high in the same cycle, the flush wins and the fill is dropped.
- R8: A fill issued in the same cycle as a lookup request is visible to that lookup's response. A fill issued in the response cycle is not visible to that response, which returns the old contents.
- R9: Two addresses that map to the same slot evict each other. After the second fill, the second address hits and the first address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_addr_i | input | ADDR_W | Lookup fetch address |
| rsp_valid_o | output | 1 | Lookup result is valid this cycle |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_insn_o | output | INSN_W | Cached decoded word on a hit, otherwise 0 |
| fill_valid_i | input | 1 | Fill request |
| fill_ok_i | input | 1 | The decode behind this fill succeeded |
| fill_addr_i | input | ADDR_W | Fill fetch address |
| fill_insn_i | input | INSN_W | Decoded word to store |
| flush_i | input | 1 | Empty every slot |

## Verification
A fill can land in the same cycle as a lookup, and a flush can land in the same cycle as a fill. Both pairings are provoked on purpose. A fill is placed once in the request cycle of a lookup and once in its response cycle. The judgement is whether that lookup reports a hit (request cycle) or the old miss (response cycle). A flush is raised together with a fill, and a later lookup of the filled address must miss. Aliasing is provoked with addresses that differ only above the hashed bits, with addresses that differ only in bit 0, and with a pair that a plain low-bit index would place in one slot.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int unsigned HASH_DN = 5;
  localparam int unsigned HASH_UP = 1;
endpackage

// File: rtl/dc_index.sv
module dc_index #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  import dc_pkg::*;
  logic [ADDR_W-1:0] half_w;
  assign half_w = addr_i >> 1;
  assign idx_o  = IDX_W'((half_w >> HASH_DN) ^ (half_w << HASH_UP));
endmodule

// File: rtl/dc_tag_array.sv
module dc_tag_array #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 2048,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_tag_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_tag_o
);
  logic [ADDR_W-1:0] tag_all [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic [ADDR_W-1:0] tag_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    tag_r <= '1;
      else if (flush_i)                               tag_r <= '1;
      else if (wr_en_i && wr_idx_i == IDX_W'(e))      tag_r <= wr_tag_i;
    end
    assign tag_all[e] = tag_r;
  end

  assign rd_tag_o = tag_all[rd_idx_i];
endmodule

// File: rtl/dc_data_array.sv
module dc_data_array #(
  parameter int unsigned INSN_W  = 64,
  parameter int unsigned ENTRIES = 2048,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [INSN_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [INSN_W-1:0] rd_data_o
);
  logic [INSN_W-1:0] mem_q [ENTRIES];

  // data needs no reset: the tag qualifies it
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/dc_cache.sv
module dc_cache #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned INSN_W  = 64,
  parameter int unsigned ENTRIES = 2048,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [INSN_W-1:0] rsp_insn_o,
  input  logic              fill_valid_i,
  input  logic              fill_ok_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [INSN_W-1:0] fill_insn_i,
  input  logic              flush_i
);
  logic              req_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [ADDR_W-1:0] rd_tag;
  logic [INSN_W-1:0] rd_data;
  logic              wr_en, tag_eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q <= lkp_valid_i;
      if (lkp_valid_i) addr_q <= lkp_addr_i;
    end
  end

  // flush beats fill
  assign wr_en = fill_valid_i & fill_ok_i & ~flush_i;

  dc_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rd_index (
    .addr_i(addr_q), .idx_o(rd_idx)
  );
  dc_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_wr_index (
    .addr_i(fill_addr_i), .idx_o(wr_idx)
  );

  dc_tag_array #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_tags (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(fill_addr_i),
    .rd_idx_i(rd_idx), .rd_tag_o(rd_tag)
  );

  dc_data_array #(.INSN_W(INSN_W), .ENTRIES(ENTRIES)) u_data (
    .clk_i(clk_i), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(fill_insn_i),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  assign tag_eq      = (rd_tag == addr_q);
  assign rsp_valid_o = req_q;
  assign rsp_hit_o   = req_q & tag_eq;
  assign rsp_insn_o  = rsp_hit_o ? rd_data : '0;
endmodule

// File: rtl/dc_cache_chk.sv
module dc_cache_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned INSN_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lkp_valid_i,
  input logic [ADDR_W-1:0] lkp_addr_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic [INSN_W-1:0] rsp_insn_o,
  input logic              fill_valid_i,
  input logic              fill_ok_i,
  input logic [ADDR_W-1:0] fill_addr_i,
  input logic [INSN_W-1:0] fill_insn_i,
  input logic              flush_i
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> rsp_valid_o); // R2
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> !rsp_valid_o); // R2
  AST_HIT_IMPLIES_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o); // R4
  AST_MISS_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> rsp_insn_o == '0); // R4
  AST_FILL_SEEN_BY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && fill_valid_i && fill_ok_i && !flush_i && lkp_addr_i == fill_addr_i
     && fill_addr_i != '1)
    |=> (rsp_hit_o && rsp_insn_o == $past(fill_insn_i))); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i ##1 (lkp_valid_i && !(fill_valid_i && fill_ok_i)) |=> !rsp_hit_o); // R6
  AST_BAD_FILL_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i ##1 (lkp_valid_i && fill_valid_i && !fill_ok_i) |=> !rsp_hit_o); // R5
endmodule

bind dc_cache dc_cache_chk #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lkp_valid_i(lkp_valid_i), .lkp_addr_i(lkp_addr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_insn_o(rsp_insn_o),
  .fill_valid_i(fill_valid_i), .fill_ok_i(fill_ok_i), .fill_addr_i(fill_addr_i),
  .fill_insn_i(fill_insn_i), .flush_i(flush_i)
);

// File: tb/dc_cache_tb.sv
module dc_cache_tb;
  localparam int unsigned AW = 32;
  localparam int unsigned IW = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lkp_valid_i = 1'b0;
  logic [AW-1:0] lkp_addr_i = '0;
  logic          rsp_valid_o, rsp_hit_o;
  logic [IW-1:0] rsp_insn_o;
  logic          fill_valid_i = 1'b0, fill_ok_i = 1'b0;
  logic [AW-1:0] fill_addr_i = '0;
  logic [IW-1:0] fill_insn_i = '0;
  logic          flush_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  dc_cache #(.ADDR_W(AW), .INSN_W(IW), .ENTRIES(2048)) u_dut (.*);

  // op: 0 lookup, 1 fill with ok, 2 fill with decode failure
  localparam int NV = 14;
  localparam logic [1:0]    V_OP   [NV] = '{0, 1, 0, 0, 1, 1, 0, 0, 2, 0, 1, 1, 0, 0};
  localparam logic [AW-1:0] V_ADDR [NV] = '{
    32'h200, 32'h200, 32'h200, 32'h201, 32'h0, 32'h1000, 32'h0, 32'h1000,
    32'h300, 32'h300, 32'h100, 32'h100100, 32'h100100, 32'h100};
  localparam logic [IW-1:0] V_INSN [NV] = '{
    64'h0, 64'hA1A1_0000_0000_0001, 64'hA1A1_0000_0000_0001, 64'h0,
    64'hB2B2_0000_0000_0002, 64'hC3C3_0000_0000_0003,
    64'hB2B2_0000_0000_0002, 64'hC3C3_0000_0000_0003,
    64'hD4D4_0000_0000_0004, 64'h0,
    64'hE5E5_0000_0000_0005, 64'hF6F6_0000_0000_0006, 64'hF6F6_0000_0000_0006, 64'h0};
  localparam logic          V_HIT  [NV] = '{0, 0, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 1, 0};
  localparam string         V_REQ  [NV] = '{"R1", "R5", "R4", "R4", "R3", "R3", "R3", "R3",
                                            "R5", "R5", "R9", "R9", "R9", "R9"};

  task automatic chk(input bit ok, input string req, input logic [IW-1:0] act,
                     input logic [IW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [AW-1:0] a, input logic [IW-1:0] d, input bit ok);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_ok_i = ok; fill_addr_i = a; fill_insn_i = d;
    @(negedge clk_i);
    fill_valid_i = 1'b0; fill_ok_i = 1'b0;
  endtask

  task automatic lookup(input logic [AW-1:0] a, input bit exp_hit,
                        input logic [IW-1:0] exp_d, input string req);
    @(negedge clk_i);
    lkp_valid_i = 1'b1; lkp_addr_i = a;
    @(negedge clk_i);
    lkp_valid_i = 1'b0;
    chk(rsp_valid_o == 1'b1, "R2", IW'(rsp_valid_o), 1);
    chk(rsp_hit_o == exp_hit, req, IW'(rsp_hit_o), IW'(exp_hit));
    chk(rsp_insn_o == (exp_hit ? exp_d : '0), req, rsp_insn_o, exp_hit ? exp_d : '0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R1", IW'(rsp_valid_o), 0);

    for (int i = 0; i < NV; i++) begin
      if (V_OP[i] == 2'd0) lookup(V_ADDR[i], V_HIT[i], V_INSN[i], V_REQ[i]);
      else                 fill(V_ADDR[i], V_INSN[i], V_OP[i] == 2'd1);
    end

    // R2: no request, no response
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R2", IW'(rsp_valid_o), 0);

    // R8: fill in response cycle is not seen, then is seen
    @(negedge clk_i);
    lkp_valid_i = 1'b1; lkp_addr_i = 32'h400;
    @(negedge clk_i);
    lkp_valid_i = 1'b0;
    fill_valid_i = 1'b1; fill_ok_i = 1'b1; fill_addr_i = 32'h400; fill_insn_i = 64'h77;
    chk(rsp_hit_o == 1'b0, "R8", IW'(rsp_hit_o), 0);
    @(negedge clk_i);
    fill_valid_i = 1'b0; fill_ok_i = 1'b0;
    lookup(32'h400, 1'b1, 64'h77, "R8");

    // R8: fill in request cycle is seen
    @(negedge clk_i);
    lkp_valid_i = 1'b1; lkp_addr_i = 32'h500;
    fill_valid_i = 1'b1; fill_ok_i = 1'b1; fill_addr_i = 32'h500; fill_insn_i = 64'h88;
    @(negedge clk_i);
    lkp_valid_i = 1'b0; fill_valid_i = 1'b0; fill_ok_i = 1'b0;
    chk(rsp_hit_o == 1'b1, "R8", IW'(rsp_hit_o), 1);
    chk(rsp_insn_o == 64'h88, "R8", rsp_insn_o, 64'h88);

    // R6: flush empties everything
    @(negedge clk_i);
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
    lookup(32'h200, 1'b0, 64'h0, "R6");
    lookup(32'h1000, 1'b0, 64'h0, "R6");
    lookup(32'h500, 1'b0, 64'h0, "R6");

    // R7: flush wins over same-cycle fill
    @(negedge clk_i);
    flush_i = 1'b1;
    fill_valid_i = 1'b1; fill_ok_i = 1'b1; fill_addr_i = 32'h600; fill_insn_i = 64'h99;
    @(negedge clk_i);
    flush_i = 1'b0; fill_valid_i = 1'b0; fill_ok_i = 1'b0;
    lookup(32'h600, 1'b0, 64'h0, "R7");

    // R1: reset mid-run empties the cache
    fill(32'h700, 64'hAA, 1'b1);
    lookup(32'h700, 1'b1, 64'hAA, "R4");
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R1", IW'(rsp_valid_o), 0);
    rst_ni = 1'b1;
    lookup(32'h700, 1'b0, 64'h0, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule